// File: doc/BRIEF.md
# Handshaked Word Register Synchronizer

This block carries a multi-bit word from a source clock domain into an unrelated destination clock domain. It looks like a register from both sides. The source writes a word with a write enable, gated by a ready flag. The destination reads a register that always holds the most recently delivered word. A one-cycle flag marks each update. The two clocks may have any frequency and phase relation.

The word is captured once in a source-side holding register. Only a single toggle request bit crosses into the destination through a flop synchronizer. When the synchronized request changes, the destination register loads the complete held word in one destination cycle, so all bits of the word change together. An acknowledge toggle returns through a second synchronizer. The writer stays stalled until that acknowledge comes back.

Delivery only means that the word reaches the destination register. Nothing ensures that destination logic looks at it before the next word replaces it. A producer that ignores the ready flag loses the words it offers while a transfer is in flight.

Top module: `wsync_top`

## Requirements
- R1: While either reset is held and right after both are released, `wrReady` is 1, `rdData` is all zeros and `rdNew` is 0.
- R2: A write is accepted on a source clock edge where `wrEn` and `wrReady` are both 1. `wrReady` is 0 from the next source cycle.
- R3: While `wrReady` is 0, `wrEn` and `wrData` are ignored. The word that is delivered is the accepted one, not any later attempt.
- R4: After a transfer, `rdData` equals the full accepted word, with all bits updated in the same destination cycle.
- R5: Each accepted write produces exactly one `rdNew` pulse, one destination cycle wide. It is high in the first cycle in which `rdData` shows the new word.
- R6: `rdData` changes only in a cycle where `rdNew` is 1.
- R7: `wrReady` returns to 1 only after the accepted word has been delivered to `rdData`.
- R8: Words arrive intact and in order when the destination clock is faster than, close to, or much slower than the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain reset, active low, asynchronous |
| wrData | input | DATA_W | Word offered for writing |
| wrEn | input | 1 | Write request; taken only when wrReady is 1 |
| wrReady | output | 1 | High when a new word can be accepted |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain reset, active low, asynchronous |
| rdData | output | DATA_W | Most recently delivered word |
| rdNew | output | 1 | One-cycle pulse marking an update of rdData |

## Verification
The assertions assume the two resets are released together while both clocks run. They also assume that a new request cannot come back around the handshake within one destination cycle. This holds because the request and acknowledge each pass through at least two flops. The stimulus keeps the destination period between about a third of the source period and nearly four times it. It changes the period only when no transfer is pending. It drives `wrEn` high while `wrReady` is 0 only to test that such writes are refused, and it drops `wrEn` before any edge where `wrReady` is 1 unless it intends the write to be taken.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadHold;   // source domain: capture wrData into holding register
    logic loadDst;    // destination domain: copy holding register to output
    logic pulseNew;   // destination domain: raise the new-data flag
  } xferStrobes_t;
endpackage

// File: rtl/wsync_bitsync.sv
module wsync_bitsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[LAST];
endmodule

// File: rtl/wsync_ctrl.sv
module wsync_ctrl
  import wsync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         srcClk,
  input  logic         srcRstN,
  input  logic         wrEn,
  output logic         wrReady,
  input  logic         dstClk,
  input  logic         dstRstN,
  output xferStrobes_t strobes
);
  logic reqTgl;       // source: flips on each accepted write
  logic ackSeen;      // source: acknowledge after synchronizer
  logic reqArrived;   // destination: request after synchronizer
  logic reqSeen;      // destination: last request acted on, doubles as ack
  logic accept;
  logic arrive;

  // source side
  assign wrReady = (reqTgl == ackSeen);
  assign accept  = wrEn && wrReady;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)    reqTgl <= 1'b0;
    else if (accept) reqTgl <= ~reqTgl;
  end

  wsync_bitsync #(.STAGES(SYNC_STAGES)) i_reqSync (
    .clk(dstClk), .rstN(dstRstN), .dIn(reqTgl), .dOut(reqArrived)
  );

  // destination side
  assign arrive = reqArrived ^ reqSeen;

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) reqSeen <= 1'b0;
    else          reqSeen <= reqArrived;
  end

  wsync_bitsync #(.STAGES(SYNC_STAGES)) i_ackSync (
    .clk(srcClk), .rstN(srcRstN), .dIn(reqSeen), .dOut(ackSeen)
  );

  assign strobes.loadHold = accept;
  assign strobes.loadDst  = arrive;
  assign strobes.pulseNew = arrive;

  // R2
  acceptDropsReady_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    accept |=> !wrReady);

  // R5
  singleLoad_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    arrive |=> !arrive);
endmodule

// File: rtl/wsync_data.sv
module wsync_data
  import wsync_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dstClk,
  input  logic              dstRstN,
  input  xferStrobes_t      strobes,
  output logic [DATA_W-1:0] holdWord,
  output logic [DATA_W-1:0] rdData,
  output logic              rdNew
);
  logic [DATA_W-1:0] holdQ;
  logic [DATA_W-1:0] rdQ;
  logic              newQ;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)              holdQ <= '0;
    else if (strobes.loadHold) holdQ <= wrData;
  end

  // whole word copied in one destination edge
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      rdQ  <= '0;
      newQ <= 1'b0;
    end else begin
      newQ <= strobes.pulseNew;
      if (strobes.loadDst) rdQ <= holdQ;
    end
  end

  assign holdWord = holdQ;
  assign rdData   = rdQ;
  assign rdNew    = newQ;

  // R6
  changeFlagged_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (rdQ != $past(rdQ)) |-> newQ);
endmodule

// File: rtl/wsync_top.sv
module wsync_top
  import wsync_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic              wrReady,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdNew
);
  xferStrobes_t      strobes;
  logic [DATA_W-1:0] holdWord;

  wsync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .wrEn(wrEn), .wrReady(wrReady),
    .dstClk(dstClk), .dstRstN(dstRstN), .strobes(strobes)
  );

  wsync_data #(.DATA_W(DATA_W)) i_data (
    .srcClk(srcClk), .srcRstN(srcRstN), .wrData(wrData),
    .dstClk(dstClk), .dstRstN(dstRstN), .strobes(strobes),
    .holdWord(holdWord), .rdData(rdData), .rdNew(rdNew)
  );

  // R3
  holdStable_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !wrReady |=> $stable(holdWord));
endmodule

// File: tb/test_wsync_top.sv
`timescale 1ns/1ps
module test_wsync_top;
  localparam int W = 32;

  logic         srcClk = 0, dstClk = 0;
  logic         srcRstN = 0, dstRstN = 0;
  logic [W-1:0] wrData = '0;
  logic         wrEn = 0;
  logic         wrReady;
  logic [W-1:0] rdData;
  logic         rdNew;

  int total = 0, bad = 0;
  int acceptCount = 0, recvCount = 0;
  int dstHalf = 3;
  logic [W-1:0] expQ[$];
  logic [W-1:0] lastRd = '0;
  bit done = 0;

  wsync_top #(.DATA_W(W)) i_wsync_top (
    .srcClk(srcClk), .srcRstN(srcRstN), .wrData(wrData), .wrEn(wrEn),
    .wrReady(wrReady), .dstClk(dstClk), .dstRstN(dstRstN),
    .rdData(rdData), .rdNew(rdNew)
  );

  always #10 srcClk = ~srcClk;  // 50 MHz
  initial forever begin #(dstHalf); dstClk = ~dstClk; end

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] junkOf(logic [W-1:0] w, int i);
    return ~w ^ (W'(i) << 3);
  endfunction

  // destination monitor: R4, R5, R6
  always @(posedge dstClk) begin
    #1;
    if (dstRstN && srcRstN) begin
      if (rdNew) begin
        recvCount++;
        if (expQ.size() == 0) check(0, "R5 pulse without write", rdData, lastRd);
        else begin
          logic [W-1:0] w;
          w = expQ.pop_front();
          check(rdData == w, "R4 delivered word", rdData, w);
        end
        lastRd = rdData;
      end else if (rdData != lastRd) begin
        check(0, "R6 change without rdNew", rdData, lastRd);
        lastRd = rdData;
      end
    end
  end

  task automatic writeWord(logic [W-1:0] w, int gap, int junkTries);
    repeat (gap) @(negedge srcClk);
    @(negedge srcClk);
    while (!wrReady) @(negedge srcClk);
    wrData = w; wrEn = 1;
    @(posedge srcClk);
    expQ.push_back(w); acceptCount++;
    @(negedge srcClk);
    wrEn = 0;
    check(wrReady == 0, "R2 ready drops after accept", W'(wrReady), '0);
    for (int i = 0; i < junkTries; i++) begin
      if (wrReady) break;
      wrData = junkOf(w, i); wrEn = 1;   // R3 refused attempts
      @(negedge srcClk);
    end
    wrEn = 0;
    while (!wrReady) @(negedge srcClk);
    check(recvCount == acceptCount, "R7 ready only after delivery",
          W'(recvCount), W'(acceptCount));
    check(rdData == w, "R3 refused writes left word intact", rdData, w);
  endtask

  task automatic runPhase(int half, int n, string tag);
    dstHalf = half;
    writeWord('1, 0, 0);
    writeWord({W/2{2'b10}}, 0, 5);
    writeWord('0, 0, 3);
    for (int k = 0; k < n; k++)
      writeWord($urandom, $urandom_range(0, 3), $urandom_range(0, 6));
    repeat (20) @(negedge srcClk);
    check(recvCount == acceptCount && expQ.size() == 0, tag,
          W'(recvCount), W'(acceptCount));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge srcClk);
    check(wrReady == 1 && rdData == '0 && rdNew == 0, "R1 in reset",
          rdData, '0);
    srcRstN = 1; dstRstN = 1;
    @(negedge srcClk);
    check(wrReady == 1, "R1 ready after reset", W'(wrReady), W'(1));
    check(rdData == '0 && rdNew == 0, "R1 output zero after reset", rdData, '0);
    runPhase(3, 40, "R8 fast destination");
    runPhase(11, 40, "R8 near ratio");
    runPhase(37, 30, "R8 slow destination");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", recvCount, acceptCount);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule